// File: doc/BRIEF.md
# SDRAM Command Sequencer with Selectable Page Policy

This block sits between a simple host request port and an SDRAM device. It takes one burst read or burst write at a time and emits the device command stream on active-low chip-select, row-strobe, column-strobe and write-enable lines. It also drives the bank and address buses and raises a strobe on each data beat. It remembers which row is open in every bank. A request that hits an open row goes straight to the column command. A request that misses first closes the bank's row, then opens the new one. A request to a closed bank opens the row first.

After reset the block stays silent until software has placed a mode word on the configuration input and pulsed the start line. It then issues one mode-register-set command and begins serving requests. The data port width fixes the burst length: 4 beats on a 64-bit port and 8 beats on a 32-bit port. Burst order is always sequential. When no request is waiting, the block closes every open row, unless the keep-open input is high. A refresh request wins over a waiting access at the next command boundary.

The request port is valid/ready. A request transfers on a rising clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host keeps `req_valid` and the request fields unchanged. `req_ready` is high only when the block is idle, the mode word has been sent, and no refresh is waiting. Beats are not back-pressured: `beat_valid` marks the cycles in which the host must supply or take data.

Top module: `sdram_cmd_seq`

## Requirements
- R1: From reset until `cfg_start` is seen, the bus carries NOP, and `req_ready` and `init_done` are low.
- R2: On `cfg_start` the block issues one mode-register-set on bank 0. Its address is the software word with bits [2:0] replaced by the burst-length code (2 for a 64-bit port, 3 for a 32-bit port) and bit 3 cleared (sequential). The CAS latency is taken from bits [6:4]. `init_done` then rises, and the next command comes no sooner than TMRD cycles later.
- R3: Commands use the encoding {cs,ras,cas,we}: MRS 0000, REF 0001, PRE 0010, ACT 0011, WR 0100, RD 0101, NOP 0111. Every cycle without a command is NOP, and the command stream is exactly the one the rules below call for.
- R4: An access to a bank with no open row issues ACT with the row on the address bus. Exactly TRCD cycles later it issues RD or WR to the same bank, with the column on the address bus and bit 10 low.
- R5: An access whose row matches the row open in its bank issues RD or WR with no ACT.
- R6: An access to a bank whose open row differs issues PRE for that bank with address bit 10 low. It then issues ACT at least TRP cycles later, followed by the column command.
- R7: `beat_valid` is high on exactly BL consecutive cycles per burst (BL=4 for a 64-bit port, 8 for a 32-bit port). A write's beats start in the cycle of the WR command. A read's beats start CL cycles after the RD command.
- R8: No command follows a column command until its last beat has passed. The gap is at least BL cycles for a write and at least CL+BL cycles for a read.
- R9: With no request waiting, `cfg_keep_open` low and some row open, the block issues PRE with address bit 10 high, which closes all banks. With `cfg_keep_open` high, an idle bus stays at NOP and rows remain open.
- R10: REF is issued only when every bank is closed. If rows are open, a precharge-all comes first, at least TRP cycles before the REF. The next command comes at least TRFC cycles after REF. All rows count as closed afterwards, so the next access activates.
- R11: A refresh request that arrives in the same cycle as a request holds `req_ready` low. The refresh sequence is issued before that access.
- R12: `req_ready` drops in the cycle after a transfer, and a request held through back-pressure is taken exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode_word | input | ADDR_W | Software-loaded mode word (CAS latency in [6:4]) |
| cfg_start | input | 1 | Pulse that triggers the mode-register-set |
| cfg_port64 | input | 1 | 1: 64-bit data port (4 beats), 0: 32-bit (8 beats) |
| cfg_keep_open | input | 1 | 1: keep rows open while the bus is idle |
| init_done | output | 1 | Mode register has been written |
| ref_req | input | 1 | Refresh request pulse |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_write | input | 1 | 1: write burst, 0: read burst |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Start column |
| beat_valid | output | 1 | Data beat strobe |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Row, column or mode address |

## Verification
A stale or wrong open-row flag shows up on the very next access to that bank. The access either issues a column command with no preceding ACT, or issues a precharge or activate that should not be there, so the command list goes wrong within a few cycles. A wrong gap counter moves the next command away from its TRCD, TRP or TRFC spacing, which shows at the following command edge. A wrong beat counter or latency register widens, narrows or shifts the `beat_valid` window within CL+BL cycles of the column command. The bench sweeps every CAS latency, both port widths and both page policies. It predicts the full command list from its own bank model.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_CFG, ST_IDLE, ST_WAIT, ST_ACT, ST_RW, ST_BURST
  } seq_state_e;

  localparam int ALL_BANKS_BIT = 10;
  localparam int BURST_WIDE    = 4;   // 64-bit port
  localparam int BURST_NARROW  = 8;   // 32-bit port
  localparam int BEAT_CNT_W    = $clog2(BURST_NARROW) + 1;

endpackage

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic              close_en,
  input  logic              close_all,
  input  logic [BANK_W-1:0] sel_bank,
  input  logic [ROW_W-1:0]  sel_row,
  output logic              sel_open,
  output logic              sel_hit,
  output logic              any_open,
  output logic [(1<<BANK_W)-1:0] open_vec
);
  localparam int NB = 1 << BANK_W;

  logic [NB-1:0] hit_vec;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic             open_b;
    logic [ROW_W-1:0] row_b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_b <= 1'b0;
        row_b  <= '0;
      end else if (close_all || (close_en && sel_bank == BANK_W'(b))) begin
        open_b <= 1'b0;
      end else if (open_en && sel_bank == BANK_W'(b)) begin
        open_b <= 1'b1;
        row_b  <= sel_row;
      end
    end
    assign open_vec[b] = open_b;
    assign hit_vec[b]  = open_b && (row_b == sel_row);
  end

  assign sel_open = open_vec[sel_bank];
  assign sel_hit  = hit_vec[sel_bank];
  assign any_open = |open_vec;

  // R10
  close_all_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |=> !any_open);

endmodule

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R6
  no_reload_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> expired);

endmodule

// File: rtl/sdram_beat_gen.sv
module sdram_beat_gen
  import sdram_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_read,
  input  logic [2:0] cas_lat,
  input  logic       bl8,
  output logic       beat_valid,
  output logic       last_beat
);
  logic [2:0]            dly_q;
  logic [BEAT_CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else if (start) begin
      dly_q <= is_read ? cas_lat : 3'd0;
      cnt_q <= bl8 ? BEAT_CNT_W'(BURST_NARROW) : BEAT_CNT_W'(BURST_WIDE);
    end else if (dly_q != '0) begin
      dly_q <= dly_q - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign beat_valid = (dly_q == '0) && (cnt_q != '0);
  assign last_beat  = beat_valid && (cnt_q == BEAT_CNT_W'(1));

  // R8
  no_burst_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (cnt_q == '0));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int TRCD   = 3,
  parameter int TRP    = 2,
  parameter int TRFC   = 6,
  parameter int TMRD   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_mode_word,
  input  logic              cfg_start,
  input  logic              cfg_port64,
  input  logic              cfg_keep_open,
  output logic              init_done,
  input  logic              ref_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              beat_valid,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [ADDR_W-1:0] sd_addr
);
  localparam int NB    = 1 << BANK_W;
  localparam int TMAX  = (TRFC > TRCD ? TRFC : TRCD) + TRP + TMRD;
  localparam int CNT_W = $clog2(TMAX) + 1;
  // Gap counts are loaded two short: one cycle for the wait-state exit, one for the output register.
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(TRCD - 2);
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(TRP - 2);
  localparam logic [CNT_W-1:0] LD_RFC = CNT_W'(TRFC - 2);
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(TMRD - 2);

  seq_state_e        state, st_d, nxt_q, nxt_d;
  sd_cmd_e           cmd_q, cmd_d;
  logic [BANK_W-1:0] ba_q, ba_d, h_bank, sel_bank;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ROW_W-1:0]  h_row, sel_row;
  logic [COL_W-1:0]  h_col, sel_col;
  logic              h_write, sel_write;
  logic              ref_pend, ref_any, ref_clr, init_q, init_set, accept;
  logic [2:0]        cl_q;
  logic              bl8_q;
  logic              open_en, close_en, close_all, sel_open, sel_hit, any_open;
  logic [NB-1:0]     open_vec;
  logic              t_load, t_expired, b_start, last_beat;
  logic [CNT_W-1:0]  t_val;

  assign ref_any   = ref_pend | ref_req;
  assign req_ready = (state == ST_IDLE) && !ref_any;
  assign sel_bank  = (state == ST_IDLE) ? req_bank  : h_bank;
  assign sel_row   = (state == ST_IDLE) ? req_row   : h_row;
  assign sel_col   = (state == ST_IDLE) ? req_col   : h_col;
  assign sel_write = (state == ST_IDLE) ? req_write : h_write;

  sdram_row_tracker #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_rows (
    .clk, .rst_n, .open_en, .close_en, .close_all,
    .sel_bank, .sel_row, .sel_open, .sel_hit, .any_open, .open_vec
  );

  sdram_gap_timer #(.CNT_W(CNT_W)) u_gap (
    .clk, .rst_n, .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  sdram_beat_gen u_beats (
    .clk, .rst_n, .start(b_start), .is_read(!sel_write),
    .cas_lat(cl_q), .bl8(bl8_q), .beat_valid, .last_beat
  );

  always_comb begin
    st_d = state;  nxt_d = nxt_q;
    cmd_d = CMD_NOP;  ba_d = '0;  addr_d = '0;
    t_load = 1'b0;  t_val = '0;  b_start = 1'b0;
    open_en = 1'b0;  close_en = 1'b0;  close_all = 1'b0;
    accept = 1'b0;  ref_clr = 1'b0;  init_set = 1'b0;
    unique case (state)
      ST_CFG: if (cfg_start) begin
        cmd_d       = CMD_MRS;
        addr_d      = cfg_mode_word;
        addr_d[3:0] = cfg_port64 ? 4'b0010 : 4'b0011;
        t_load = 1'b1;  t_val = LD_MRD;  nxt_d = ST_IDLE;  st_d = ST_WAIT;
        init_set = 1'b1;
      end
      ST_IDLE: begin
        if (ref_any) begin
          if (any_open) begin
            cmd_d = CMD_PRE;  addr_d[ALL_BANKS_BIT] = 1'b1;  close_all = 1'b1;
            t_load = 1'b1;  t_val = LD_RP;
          end else begin
            cmd_d = CMD_REF;  ref_clr = 1'b1;
            t_load = 1'b1;  t_val = LD_RFC;
          end
          nxt_d = ST_IDLE;  st_d = ST_WAIT;
        end else if (req_valid) begin
          accept = 1'b1;
          if (sel_hit) begin
            cmd_d = sel_write ? CMD_WR : CMD_RD;
            ba_d = sel_bank;  addr_d[COL_W-1:0] = sel_col;
            b_start = 1'b1;  st_d = ST_BURST;
          end else if (sel_open) begin
            cmd_d = CMD_PRE;  ba_d = sel_bank;  close_en = 1'b1;
            t_load = 1'b1;  t_val = LD_RP;  nxt_d = ST_ACT;  st_d = ST_WAIT;
          end else begin
            cmd_d = CMD_ACT;  ba_d = sel_bank;  addr_d[ROW_W-1:0] = sel_row;
            open_en = 1'b1;
            t_load = 1'b1;  t_val = LD_RCD;  nxt_d = ST_RW;  st_d = ST_WAIT;
          end
        end else if (!cfg_keep_open && any_open) begin
          cmd_d = CMD_PRE;  addr_d[ALL_BANKS_BIT] = 1'b1;  close_all = 1'b1;
          t_load = 1'b1;  t_val = LD_RP;  nxt_d = ST_IDLE;  st_d = ST_WAIT;
        end
      end
      ST_WAIT: if (t_expired) st_d = nxt_q;
      ST_ACT: begin
        cmd_d = CMD_ACT;  ba_d = sel_bank;  addr_d[ROW_W-1:0] = sel_row;
        open_en = 1'b1;
        t_load = 1'b1;  t_val = LD_RCD;  nxt_d = ST_RW;  st_d = ST_WAIT;
      end
      ST_RW: begin
        cmd_d = sel_write ? CMD_WR : CMD_RD;
        ba_d = sel_bank;  addr_d[COL_W-1:0] = sel_col;
        b_start = 1'b1;  st_d = ST_BURST;
      end
      ST_BURST: if (last_beat) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CFG;  nxt_q <= ST_IDLE;  cmd_q <= CMD_NOP;
      ba_q <= '0;  addr_q <= '0;
      h_write <= 1'b0;  h_bank <= '0;  h_row <= '0;  h_col <= '0;
      ref_pend <= 1'b0;  init_q <= 1'b0;  cl_q <= 3'd1;  bl8_q <= 1'b0;
    end else begin
      state <= st_d;  nxt_q <= nxt_d;  cmd_q <= cmd_d;
      ba_q <= ba_d;  addr_q <= addr_d;
      if (accept) begin
        h_write <= req_write;  h_bank <= req_bank;
        h_row <= req_row;  h_col <= req_col;
      end
      ref_pend <= (ref_pend | ref_req) & ~ref_clr;
      if (init_set) begin
        init_q <= 1'b1;
        cl_q   <= cfg_mode_word[6:4];
        bl8_q  <= ~cfg_port64;
      end
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba     = ba_q;
  assign sd_addr   = addr_q;
  assign init_done = init_q;

  // R4
  col_cmd_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> open_vec[ba_q]);

  // R10
  refresh_all_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_REF) |-> !any_open);

  // R12
  ready_drops_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R1
  quiet_before_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_q |-> (cmd_q == CMD_NOP));

endmodule

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;
  localparam int TRCD = 3, TRP = 2, TRFC = 6, TMRD = 2;
  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [12:0] cfg_mode_word = '0;
  logic cfg_start = 0, cfg_port64 = 0, cfg_keep_open = 0, ref_req = 0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0] req_col = '0;
  logic init_done, req_ready, beat_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [12:0] sd_addr;

  sdram_cmd_seq u_sdram_cmd_seq (
    .clk, .rst_n, .cfg_mode_word, .cfg_start, .cfg_port64, .cfg_keep_open,
    .init_done, .ref_req, .req_valid, .req_ready, .req_write, .req_bank,
    .req_row, .req_col, .beat_valid, .sd_cs_n, .sd_ras_n, .sd_cas_n,
    .sd_we_n, .sd_ba, .sd_addr
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int cur_cl = 1, cur_bl = 4;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // observed and expected command lists
  logic [3:0] log_cmd [64];  logic [1:0] log_ba [64];  logic [12:0] log_addr [64];
  logic [3:0] exp_cmd [64];  logic [1:0] exp_ba [64];  logic [12:0] exp_addr [64];
  int n_log = 0, n_exp = 0;

  task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a);
    if (n_exp < 64) begin
      exp_cmd[n_exp] = c;  exp_ba[n_exp] = b;  exp_addr[n_exp] = a;  n_exp++;
    end
  endtask

  // bus monitor: gaps (R2 R4 R6 R8 R10) and beat windows (R7)
  bit prev_ok = 0, bw_arm = 0;
  logic [3:0] prev_cmd;
  int prev_cyc = 0, prev_d = 0, bw_lo = 0, bw_hi = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ok = 0;  bw_arm = 0;
    end else begin
      logic [3:0] bus;
      bit expb;
      int g;
      bus = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (bus != C_NOP) begin
        if (n_log < 64) begin
          log_cmd[n_log] = bus;  log_ba[n_log] = sd_ba;  log_addr[n_log] = sd_addr;  n_log++;
        end
        if (prev_ok) begin
          g = cyc - prev_cyc;
          case (prev_cmd)
            C_ACT: check(g == TRCD, "R4", "ACT to column gap", g, TRCD);
            C_PRE: check(g >= TRP, "R6", "precharge gap", g, TRP);
            C_REF: check(g >= TRFC, "R10", "refresh gap", g, TRFC);
            C_MRS: check(g >= TMRD, "R2", "mode-set gap", g, TMRD);
            default: check(g >= prev_d + cur_bl, "R8", "burst gap", g, prev_d + cur_bl);
          endcase
        end
        prev_ok = 1;  prev_cmd = bus;  prev_cyc = cyc;
        if (bus == C_RD || bus == C_WR) begin
          prev_d = (bus == C_RD) ? cur_cl : 0;
          bw_arm = 1;  bw_lo = cyc + prev_d;  bw_hi = bw_lo + cur_bl - 1;
        end
      end
      expb = bw_arm && cyc >= bw_lo && cyc <= bw_hi;
      if (expb || beat_valid)
        check(beat_valid == expb, "R7", "beat strobe", beat_valid, expb);
    end
  end

  // bench bank model
  bit m_open [4];  logic [12:0] m_row [4];

  task automatic send(input bit wr, input logic [1:0] b, input logic [12:0] r,
                      input logic [9:0] c, input bit with_ref);
    if (m_open[b] && m_row[b] == r) begin
      push(wr ? C_WR : C_RD, b, {3'b0, c});
    end else begin
      if (m_open[b]) push(C_PRE, b, 13'h0);
      push(C_ACT, b, r);
      push(wr ? C_WR : C_RD, b, {3'b0, c});
    end
    m_open[b] = 1;  m_row[b] = r;
    @(negedge clk);
    req_valid = 1;  req_write = wr;  req_bank = b;  req_row = r;  req_col = c;
    ref_req = with_ref;
    #1;
    if (with_ref) begin
      check(req_ready == 0, "R11", "ready with refresh pending", req_ready, 0);
      @(negedge clk);
      ref_req = 0;
      #1;
    end
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    check(req_ready == 0, "R12", "ready after transfer", req_ready, 0);
  endtask

  task automatic go_idle(input int cycles);
    @(negedge clk);
    req_valid = 0;
    if (!cfg_keep_open && (m_open[0] | m_open[1] | m_open[2] | m_open[3])) begin
      push(C_PRE, 2'd0, 13'h0400);
      for (int i = 0; i < 4; i++) m_open[i] = 0;
    end
    repeat (cycles) @(negedge clk);
  endtask

  task automatic refresh_expect();
    if (m_open[0] | m_open[1] | m_open[2] | m_open[3]) push(C_PRE, 2'd0, 13'h0400);
    push(C_REF, 2'd0, 13'h0);
    for (int i = 0; i < 4; i++) m_open[i] = 0;
  endtask

  function automatic string req_of(input logic [3:0] c, input logic [12:0] a);
    case (c)
      C_MRS: return "R2";
      C_ACT: return "R4";
      C_RD, C_WR: return "R5";
      C_PRE: return a[10] ? "R9" : "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic run_config(input int cl, input bit p64, input bit keep);
    logic [12:0] word;
    cur_cl = cl;  cur_bl = p64 ? 4 : 8;
    n_log = 0;  n_exp = 0;
    for (int i = 0; i < 4; i++) m_open[i] = 0;
    cfg_port64 = p64;  cfg_keep_open = keep;  req_valid = 0;  ref_req = 0;  cfg_start = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: quiet until start
    check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP && n_log == 0, "R1",
          "bus before start", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    check(req_ready == 0 && init_done == 0, "R1", "ready/init before start",
          {req_ready, init_done}, 0);
    word = {6'b000101, 3'(cl), 4'b1111};
    cfg_mode_word = word;
    push(C_MRS, 2'd0, {word[12:4], 1'b0, p64 ? 3'd2 : 3'd3});
    cfg_start = 1;
    @(negedge clk);
    cfg_start = 0;
    repeat (4) @(negedge clk);
    check(init_done == 1, "R2", "init_done after mode-set", init_done, 1);
    // back-to-back: empty, hit, miss, other bank
    send(0, 2'd0, 13'd5, 10'd3, 0);
    send(1, 2'd0, 13'd5, 10'd8, 0);
    send(0, 2'd0, 13'd9, 10'd1, 0);
    send(1, 2'd2, 13'd1, 10'd0, 0);
    go_idle(15);
    // refresh arriving together with a request
    refresh_expect();
    send(1, 2'd0, 13'd9, 10'd2, 1);
    go_idle(15);
    // page kept or closed across idle
    send(0, 2'd0, 13'd9, 10'd7, 0);
    go_idle(30);
    check(n_log == n_exp, "R3", "command count", n_log, n_exp);
    for (int i = 0; i < n_log && i < n_exp; i++) begin
      check(log_cmd[i] == exp_cmd[i], req_of(exp_cmd[i], exp_addr[i]), "command code",
            log_cmd[i], exp_cmd[i]);
      if (exp_cmd[i] == C_PRE)
        check(log_addr[i][10] == exp_addr[i][10] && (exp_addr[i][10] || log_ba[i] == exp_ba[i]),
              req_of(exp_cmd[i], exp_addr[i]), "precharge scope",
              {log_ba[i], log_addr[i][10]}, {exp_ba[i], exp_addr[i][10]});
      else if (exp_cmd[i] != C_REF)
        check(log_addr[i] == exp_addr[i] && log_ba[i] == exp_ba[i],
              req_of(exp_cmd[i], exp_addr[i]), "bank/address",
              {log_ba[i], log_addr[i]}, {exp_ba[i], exp_addr[i]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;  fails++;
    $display("FAIL R1 watchdog: actual=%0d cycles expected=completion", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int cl = 1; cl <= 4; cl++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 2; k++)
          run_config(cl, p[0], k[0]);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule